// File: doc/BRIEF.md
# Long-Press Reset Button Controller

This block turns a single reset pushbutton into two distinct reset actions, chosen by how long the button is held. It first synchronizes the raw button level. It then qualifies a press with a debounce window measured in ticks of a prescaled time base. A qualified press that ends before the long threshold asks for a plain system reset. A press held through the long threshold asks for a reset and also records that the next boot must take its configuration from a fixed ROM.

The record is one mode bit that drives two registered, complementary, active-low enables. One gates the NVRAM chip select and the other gates the ROM chip select. The bit survives the reset pulse this block issues. Only the power-on reset input or a one-cycle software strobe on a GPIO line can clear it, and software uses that strobe once it has booted from ROM and wants to rewrite the NVRAM. The debounce window and the long threshold are parameters counted in time-base ticks. With a 1 ms tick they would be about 100 and 3000.

Top module: `lpress_rst_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `sys_rst` is 0, `nvram_cs_en_n` is 0 and `rom_cs_en_n` is 1, which means the NVRAM is the selected boot source.
- R2: A press is sampled once, on the DEB_TICKS-th `tick` after the synchronized button rises. If the button is then low, the press is dropped, no `sys_rst` pulse follows, and the block rearms.
- R3: A press that passes the debounce sample and is released before LONG_TICKS further ticks have been counted gives exactly one `sys_rst` pulse. This holds for releases under one second and between one and three seconds alike, and the mode bit is left unchanged.
- R4: A press still held when the LONG_TICKS-th tick after the debounce sample arrives gives one `sys_rst` pulse at once and sets the mode bit. With the bit set, `nvram_cs_en_n` is 1 and `rom_cs_en_n` is 0.
- R5: `nvram_cs_en_n` and `rom_cs_en_n` are always complements of each other.
- R6: Once set, the mode bit holds through the block's own `sys_rst` pulse and through later short presses.
- R7: A one-cycle high on `mode_clr` clears the mode bit from the next cycle on, so `nvram_cs_en_n` becomes 0 and `rom_cs_en_n` becomes 1.
- R8: If `mode_clr` arrives in the same cycle as the decision to fire a long press, setting wins and the mode bit ends set.
- R9: A press gives at most one `sys_rst` pulse, however long it is held. The block does not rearm until the pulse has ended and the button has been released.
- R10: Each `sys_rst` pulse is high for exactly PULSE_LEN consecutive clock cycles (16 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_raw | input | 1 | Raw button level, 1 = pressed, asynchronous |
| tick | input | 1 | One-cycle strobe from the prescaled time base |
| mode_clr | input | 1 | Software strobe that clears the mode bit |
| sys_rst | output | 1 | System reset pulse, PULSE_LEN cycles long |
| nvram_cs_en_n | output | 1 | Active-low enable for the NVRAM chip select |
| rom_cs_en_n | output | 1 | Active-low enable for the ROM chip select |

## Verification
Two functions can fall in the same clock cycle: setting the mode bit when a long press fires, and clearing it through the software strobe. The bench provokes this by raising `mode_clr` together with the very tick that completes the long threshold. It then judges the result at the chip-select enables once the pulse has passed, expecting the ROM to remain selected. A sweep over every hold length, from zero ticks to past the long threshold, checks the pulse length and the mode bit on both sides of each boundary.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DEBOUNCE = 2'd1,
    ST_TIMING   = 2'd2,
    ST_FIRE     = 2'd3
  } lpr_state_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lpr_press_fsm.sv
module lpr_press_fsm
  import lpr_pkg::*;
#(
  parameter int DEB_TICKS  = 100,
  parameter int LONG_TICKS = 3000,
  localparam int MAXT  = (DEB_TICKS > LONG_TICKS) ? DEB_TICKS : LONG_TICKS,
  localparam int CNT_W = $clog2(MAXT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_s,
  input  logic tick,
  input  logic pulse_busy,
  output logic fire_req,
  output logic fire_long
);
  localparam logic [CNT_W-1:0] DEB_LAST  = CNT_W'(DEB_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_TICKS - 1);

  lpr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    fire_req  = 1'b0;
    fire_long = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (btn_s) begin
          state_d = ST_DEBOUNCE;
          cnt_d   = '0;
        end
      end
      ST_DEBOUNCE: begin
        if (tick) begin
          if (cnt_q == DEB_LAST) begin
            cnt_d   = '0;
            state_d = btn_s ? ST_TIMING : ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_TIMING: begin
        if (!btn_s) begin
          state_d  = ST_FIRE;
          fire_req = 1'b1;
        end else if (tick) begin
          if (cnt_q == LONG_LAST) begin
            state_d   = ST_FIRE;
            fire_req  = 1'b1;
            fire_long = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_FIRE: begin
        if (!pulse_busy && !btn_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lpr_pulse.sv
module lpr_pulse #(
  parameter int PULSE_LEN = 16,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse
);
  logic [PW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      left_q  <= PW'(PULSE_LEN - 1);
      pulse_q <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/lpr_mode_latch.sv
module lpr_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nv_en_n,
  output logic rom_en_n
);
  logic nv_q, rom_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_q  <= 1'b0;
      rom_q <= 1'b1;
    end else if (set_i) begin
      nv_q  <= 1'b1;
      rom_q <= 1'b0;
    end else if (clr_i) begin
      nv_q  <= 1'b0;
      rom_q <= 1'b1;
    end
  end

  assign nv_en_n  = nv_q;
  assign rom_en_n = rom_q;
endmodule

// File: rtl/lpress_rst_ctrl.sv
module lpress_rst_ctrl #(
  parameter int DEB_TICKS   = 100,
  parameter int LONG_TICKS  = 3000,
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  input  logic tick,
  input  logic mode_clr,
  output logic sys_rst,
  output logic nvram_cs_en_n,
  output logic rom_cs_en_n
);
  logic btn_s;
  logic fire_req;
  logic fire_long;
  logic pulse_busy;

  lpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (btn_raw),
    .d_out (btn_s)
  );

  lpr_press_fsm #(.DEB_TICKS(DEB_TICKS), .LONG_TICKS(LONG_TICKS)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .btn_s      (btn_s),
    .tick       (tick),
    .pulse_busy (pulse_busy),
    .fire_req   (fire_req),
    .fire_long  (fire_long)
  );

  lpr_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .start (fire_req),
    .pulse (pulse_busy)
  );

  lpr_mode_latch u_mode (
    .clk      (clk),
    .rst      (rst),
    .set_i    (fire_long),
    .clr_i    (mode_clr),
    .nv_en_n  (nvram_cs_en_n),
    .rom_en_n (rom_cs_en_n)
  );

  assign sys_rst = pulse_busy;
endmodule

// File: rtl/lpress_rst_chk.sv
module lpress_rst_chk #(
  parameter int PULSE_LEN = 16,
  localparam int RW = $clog2(PULSE_LEN + 2) + 1
) (
  input logic clk,
  input logic rst,
  input logic sys_rst,
  input logic nvram_cs_en_n,
  input logic rom_cs_en_n,
  input logic mode_clr,
  input logic fire_req,
  input logic fire_long
);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (sys_rst) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R5
  cs_compl_chk: assert property (@(posedge clk) disable iff (rst)
    nvram_cs_en_n != rom_cs_en_n);

  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_clr && !fire_long) |=> (!nvram_cs_en_n && rom_cs_en_n));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    fire_long |=> (nvram_cs_en_n && !rom_cs_en_n));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_clr && !fire_long) |=> $stable(nvram_cs_en_n));

  // R9
  no_refire_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> !fire_req);

  // R10
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    fire_req |=> sys_rst);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (run_q == RW'(PULSE_LEN)));
endmodule

bind lpress_rst_ctrl lpress_rst_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sys_rst       (sys_rst),
  .nvram_cs_en_n (nvram_cs_en_n),
  .rom_cs_en_n   (rom_cs_en_n),
  .mode_clr      (mode_clr),
  .fire_req      (fire_req),
  .fire_long     (fire_long)
);

// File: tb/lpress_rst_ctrl_tb.sv
`timescale 1ns/1ps
module lpress_rst_ctrl_tb;
  localparam int DEB  = 3;
  localparam int LONG = 10;
  localparam int PLEN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic tick = 1'b0;
  logic mode_clr = 1'b0;
  logic sys_rst, nvram_cs_en_n, rom_cs_en_n;

  int total = 0;
  int bad = 0;
  int hi_cnt = 0;
  int run = 0;
  int max_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpress_rst_ctrl #(
    .DEB_TICKS(DEB), .LONG_TICKS(LONG), .PULSE_LEN(PLEN), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .tick(tick),
    .mode_clr(mode_clr), .sys_rst(sys_rst),
    .nvram_cs_en_n(nvram_cs_en_n), .rom_cs_en_n(rom_cs_en_n)
  );

  always @(negedge clk) begin
    if (sys_rst) begin
      hi_cnt <= hi_cnt + 1;
      run    <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_tick(input bit with_clr);
    @(posedge clk); #1;
    tick = 1'b1;
    mode_clr = with_clr;
    @(posedge clk); #1;
    tick = 1'b0;
    mode_clr = 1'b0;
    cyc(2);
  endtask

  task automatic sw_clear();
    @(posedge clk); #1;
    mode_clr = 1'b1;
    @(posedge clk); #1;
    mode_clr = 1'b0;
    cyc(1);
  endtask

  // hold for t ticks; optional clear strobe on the last tick
  task automatic press(input int t, input bit clr_last);
    hi_cnt = 0;
    max_run = 0;
    @(posedge clk); #1;
    btn_raw = 1'b1;
    cyc(4);
    for (int i = 0; i < t; i++) pulse_tick(clr_last && (i == t - 1));
    btn_raw = 1'b0;
    cyc(4);
    for (int i = 0; i < DEB + 2; i++) pulse_tick(1'b0);
    cyc(30);
  endtask

  task automatic look_mode(input string req, input int exp_mode);
    @(negedge clk);
    check(req, int'(nvram_cs_en_n), exp_mode);
    check(req, int'(rom_cs_en_n), 1 - exp_mode);
  endtask

  initial begin
    cyc(3);
    @(negedge clk);
    check("R1 sys_rst in reset", int'(sys_rst), 0);
    check("R1 nvram_n in reset", int'(nvram_cs_en_n), 0);
    check("R1 rom_n in reset", int'(rom_cs_en_n), 1);
    @(posedge clk); #1;
    rst = 1'b0;
    cyc(2);
    look_mode("R1 after reset", 0);

    // sweep hold length across every boundary
    for (int t = 0; t <= DEB + LONG + 2; t++) begin
      int exp_p;
      int exp_m;
      exp_p = (t >= DEB) ? PLEN : 0;
      exp_m = (t >= DEB + LONG) ? 1 : 0;
      sw_clear();
      press(t, 1'b0);
      if (t < DEB)             check("R2 dropped press pulse", hi_cnt, exp_p);
      else if (t < DEB + LONG) check("R3 short press pulse", hi_cnt, exp_p);
      else                     check("R9 single pulse on long hold", hi_cnt, exp_p);
      if (t >= DEB) check("R10 contiguous pulse", max_run, PLEN);
      if (t < DEB + LONG) look_mode("R3 mode unchanged", exp_m);
      else                look_mode("R4 long press sets mode", exp_m);
    end

    // R6: a short press leaves a set mode bit alone
    press(DEB + 1, 1'b0);
    check("R6 short pulse while set", hi_cnt, PLEN);
    look_mode("R6 mode retained", 1);

    // R7: software clear
    sw_clear();
    look_mode("R7 clear strobe", 0);

    // R8: clear in the same cycle as the long decision
    press(DEB + LONG, 1'b1);
    check("R8 pulse", hi_cnt, PLEN);
    look_mode("R8 set wins over clear", 1);
    sw_clear();
    look_mode("R7 clear after R8", 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule